// File: doc/BRIEF.md
# Multiplexed DRAM Strobe Sequencer with Hidden Refresh

This block drives a dynamic RAM that has a single 8-bit multiplexed address port. It sits on a synchronous processor bus whose cycle is framed by two quadrature phase signals, E and Q. A cycle begins when E falls, Q rises a quarter later, then E rises and Q falls. The block runs on a fast clock, at least eight clocks per bus cycle, and samples both phases on that clock. It splits the 16-bit processor address into a row half (low byte) and a column half (high byte). It then places each half on the RAM address pins before the matching strobe falls.

Refresh costs the processor nothing. In a bus cycle where the RAM chip select is inactive, the row address comes from an internal 7-bit refresh counter, and only the row strobe is pulsed. Such a cycle is a RAS-only refresh. The counter steps to the next row at the end of each refresh cycle and holds through selected cycles, so every one of the 128 rows is visited in increasing order with none skipped.

Top module: `dram_refresh_ctl`

## Requirements
- R1: While rstN is low the outputs are idle: rasN, casN and weN high, dataOe low, memAddr zero. The refresh counter starts at row 0.
- R2: In every bus cycle rasN goes low on the second clock of the Q-high/E-low quarter. It stays low while E is high and returns high on the first clock after E falls.
- R3: In a selected cycle memAddr carries cpuAddr[7:0] from the first clock of the Q-high/E-low quarter. That is one clock before rasN falls.
- R4: In a selected cycle memAddr switches to cpuAddr[15:8] on the first clock with E high. casN goes low one clock later and returns high on the first clock after E falls.
- R5: In a cycle where chipSel was low at the Q rise, casN stays high for the whole cycle. memAddr carries the refresh row, zero-extended to 8 bits, from one clock before rasN falls until the cycle ends.
- R6: The refresh row advances by one after every unselected cycle and holds across selected cycles.
- R7: The refresh row wraps from 127 to 0.
- R8: rdWr=0 means write and rdWr=1 means read. In a selected write weN is low exactly when casN is low. In a read weN stays high.
- R9: In a selected read dataOe is high exactly when casN is low. In a write, or in a refresh cycle, dataOe stays low.
- R10: chipSel, rdWr and cpuAddr are taken on the first clock of the Q-high/E-low quarter. Later changes within the same cycle have no effect on memAddr, casN, weN or dataOe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, at least two periods per bus quarter |
| rstN | input | 1 | Active-low synchronous reset |
| busE | input | 1 | Bus E phase, synchronous to clk |
| busQ | input | 1 | Bus Q phase, leads E by a quarter |
| chipSel | input | 1 | RAM selected in this bus cycle |
| rdWr | input | 1 | 1 = read, 0 = write |
| cpuAddr | input | 16 | Processor address, row in the low byte, column in the high byte |
| memAddr | output | 8 | Multiplexed RAM address |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | RAM write enable, active low |
| dataOe | output | 1 | Enables RAM read data onto the processor bus |

## Verification
The checks assume that E and Q follow the quadrature order 00, 01, 11, 10, and that each quarter lasts at least two clocks. They also assume that address, select and direction are valid by the Q rise. If these assumptions break, a strobe could fall in the same clock as its address changes. The stimulus produces exactly that phase order, with two clocks per quarter, and sets chipSel, rdWr and cpuAddr at the start of each cycle. In some cycles these inputs are then deliberately changed after the Q rise, to show that the values taken at the Q rise are the ones used.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  // Single-clock pulses from the sequencer to the address path.
  typedef struct packed {
    logic latchRow;     // first clock of Q-high quarter: pick row source
    logic pickCol;      // first clock of E-high in a selected cycle
    logic stepRefresh;  // E fall closing an unselected cycle
  } strobe_t;

endpackage

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_refresh_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    busE,
  input  logic    busQ,
  input  logic    chipSel,
  input  logic    rdWr,
  output strobe_t strobe,
  output logic    rasN,
  output logic    casN,
  output logic    weN,
  output logic    dataOe
);

  logic prevE, prevQ;
  logic cycSel, cycWr;
  logic qRiseFirst, eRiseFirst, eFall;
  logic rasLowNext, casLowNext;

  assign qRiseFirst = busQ && !busE && !prevQ;
  assign eRiseFirst = busE && !prevE;
  assign eFall      = !busE && prevE;

  // RAS waits one clock into the Q quarter so the row is already stable.
  assign rasLowNext = (busE || busQ) && (prevE || prevQ);
  // CAS waits one clock into E-high so the column is already stable.
  assign casLowNext = cycSel && busE && prevE;

  always_comb begin
    strobe.latchRow    = qRiseFirst;
    strobe.pickCol     = eRiseFirst && cycSel;
    strobe.stepRefresh = eFall && !cycSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevE  <= 1'b0;
      prevQ  <= 1'b0;
      cycSel <= 1'b0;
      cycWr  <= 1'b0;
      rasN   <= 1'b1;
      casN   <= 1'b1;
      weN    <= 1'b1;
      dataOe <= 1'b0;
    end else begin
      prevE <= busE;
      prevQ <= busQ;
      if (qRiseFirst) begin
        cycSel <= chipSel;
        cycWr  <= !rdWr;
      end
      rasN   <= !rasLowNext;
      casN   <= !casLowNext;
      weN    <= !(casLowNext && cycWr);
      dataOe <= casLowNext && !cycWr;
    end
  end

  p_cas_inside_ras_r4: assert property (@(posedge clk) disable iff (!rstN)
    !casN |-> !rasN);

  p_we_inside_cas_r8: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> !casN);

  p_oe_read_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (weN && !casN));

  p_release_on_efall_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busE) && !busE) |=> (rasN && casN));

endmodule

// File: rtl/dram_addr_path.sv
module dram_addr_path
  import dram_refresh_pkg::*;
#(
  parameter int CPU_AW = 16,
  parameter int MUX_AW = 8,
  parameter int ROWS   = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              chipSel,
  input  logic [CPU_AW-1:0] cpuAddr,
  output logic [MUX_AW-1:0] memAddr
);

  localparam int CNT_W = $clog2(ROWS);
  localparam int PAD_W = MUX_AW - CNT_W;

  logic [CNT_W-1:0]  refCnt;
  logic [MUX_AW-1:0] refRow;
  logic [MUX_AW-1:0] colHold;
  logic [MUX_AW-1:0] cpuRow, cpuCol;

  assign cpuRow = cpuAddr[MUX_AW-1:0];
  assign cpuCol = cpuAddr[2*MUX_AW-1:MUX_AW];

  generate
    if (PAD_W > 0) begin : g_pad
      assign refRow = {{PAD_W{1'b0}}, refCnt};
    end else begin : g_nopad
      assign refRow = refCnt[MUX_AW-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refCnt  <= '0;
      colHold <= '0;
      memAddr <= '0;
    end else begin
      if (strobe.latchRow) begin
        memAddr <= chipSel ? cpuRow : refRow;
        colHold <= cpuCol;
      end else if (strobe.pickCol) begin
        memAddr <= colHold;
      end
      if (strobe.stepRefresh)
        refCnt <= (refCnt == CNT_W'(ROWS - 1)) ? '0 : refCnt + 1'b1;
    end
  end

  p_refresh_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (refCnt != $past(refCnt)) |->
      ((refCnt == '0 && $past(refCnt) == CNT_W'(ROWS - 1)) ||
       (refCnt == $past(refCnt) + 1'b1)));

endmodule

// File: rtl/dram_refresh_ctl.sv
module dram_refresh_ctl
  import dram_refresh_pkg::*;
#(
  parameter int CPU_AW = 16,
  parameter int MUX_AW = 8,
  parameter int ROWS   = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busE,
  input  logic              busQ,
  input  logic              chipSel,
  input  logic              rdWr,
  input  logic [CPU_AW-1:0] cpuAddr,
  output logic [MUX_AW-1:0] memAddr,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              dataOe
);

  strobe_t strobe;

  dram_seq_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busE    (busE),
    .busQ    (busQ),
    .chipSel (chipSel),
    .rdWr    (rdWr),
    .strobe  (strobe),
    .rasN    (rasN),
    .casN    (casN),
    .weN     (weN),
    .dataOe  (dataOe)
  );

  dram_addr_path #(
    .CPU_AW (CPU_AW),
    .MUX_AW (MUX_AW),
    .ROWS   (ROWS)
  ) i_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .chipSel (chipSel),
    .cpuAddr (cpuAddr),
    .memAddr (memAddr)
  );

  // Address must already be settled on the clock a strobe falls.
  p_row_setup_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> $stable(memAddr));

  p_col_setup_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> $stable(memAddr));

endmodule

// File: tb/test_dram_refresh_ctl.sv
module test_dram_refresh_ctl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busE = 1'b0, busQ = 1'b0, chipSel = 1'b0, rdWr = 1'b1;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  memAddr;
  logic        rasN, casN, weN, dataOe;

  int errors = 0;
  int checks = 0;
  int refRow = 0;
  int wraps  = 0;
  bit prevValid = 0, prevSel = 0, done = 0;

  always #4 clk = ~clk;

  dram_refresh_ctl i_dram_refresh_ctl (
    .clk(clk), .rstN(rstN), .busE(busE), .busQ(busQ), .chipSel(chipSel),
    .rdWr(rdWr), .cpuAddr(cpuAddr), .memAddr(memAddr), .rasN(rasN),
    .casN(casN), .weN(weN), .dataOe(dataOe)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One bus cycle of eight clocks; reference state is just refRow.
  task automatic busCycle(bit sel, bit wr, logic [15:0] a, bit disturb);
    for (int t = 0; t < 8; t++) begin
      int ph = t / 2;
      logic [7:0] expAddr;
      string aTag;
      busQ = (ph == 1 || ph == 2);
      busE = (ph >= 2);
      if (t == 0) begin
        chipSel = sel; rdWr = !wr; cpuAddr = a;
        if (prevValid && !prevSel) begin
          refRow = (refRow + 1) % 128;
          if (refRow == 0) wraps++;
        end
      end
      if (t == 4 && disturb) begin  // R10: late changes ignored
        chipSel = !sel; rdWr = wr; cpuAddr = ~a;
      end
      @(negedge clk);
      chk(disturb ? "R10 rasN" : "R2 rasN", 16'(rasN), (t >= 3) ? 16'd0 : 16'd1);
      chk(disturb ? "R10 casN" : (sel ? "R4 casN" : "R5 casN"), 16'(casN),
          (sel && t >= 5) ? 16'd0 : 16'd1);
      chk(disturb ? "R10 weN" : "R8 weN", 16'(weN),
          (sel && wr && t >= 5) ? 16'd0 : 16'd1);
      chk(disturb ? "R10 dataOe" : "R9 dataOe", 16'(dataOe),
          (sel && !wr && t >= 5) ? 16'd1 : 16'd0);
      if (t >= 2) begin
        if (sel) begin
          expAddr = (t >= 4) ? a[15:8] : a[7:0];
          aTag    = (t >= 4) ? "R4 memAddr col" : "R3 memAddr row";
        end else begin
          expAddr = 8'(refRow);
          aTag    = (wraps > 0 && refRow == 0) ? "R7 memAddr wrap" : "R6 memAddr refresh";
        end
        if (disturb) aTag = "R10 memAddr";
        chk(aTag, 16'(memAddr), 16'(expAddr));
      end
    end
    prevValid = 1;
    prevSel   = sel;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rasN reset", 16'(rasN), 16'd1);
    chk("R1 casN reset", 16'(casN), 16'd1);
    chk("R1 weN reset", 16'(weN), 16'd1);
    chk("R1 dataOe reset", 16'(dataOe), 16'd0);
    chk("R1 memAddr reset", 16'(memAddr), 16'd0);
    rstN = 1'b1;

    busCycle(0, 0, 16'h0000, 0);       // R5 refresh row 0
    busCycle(0, 0, 16'hFFFF, 0);
    busCycle(1, 0, 16'h3C5A, 0);       // read
    busCycle(1, 1, 16'hA5C3, 0);       // write, R6 hold
    busCycle(0, 1, 16'h1111, 0);
    busCycle(1, 0, 16'h1234, 1);       // disturbed read
    busCycle(0, 0, 16'h4321, 1);       // disturbed refresh
    busCycle(1, 1, 16'hBEEF, 1);       // disturbed write
    for (int i = 0; i < 130; i++)      // R7 wrap
      busCycle(0, i % 2, 16'(i * 16'h0101), 0);
    for (int i = 0; i < 24; i++)
      busCycle(i % 3 != 0, i % 2, 16'(i * 16'h1357 + 16'h0F0F), i % 5 == 4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule